// File: doc/BRIEF.md
# Multiply-Accumulate Execution Unit

This unit carries out 32×32 multiply and multiply-accumulate operations with 64-bit operands. It holds the accumulator in a pair of 64-bit registers, HI and LO, and takes one operation at a time through a valid/ready handshake. The operation comes as a 32-bit instruction word together with the two source register values. The unit decodes the word into its mode controls: accumulate, subtract, unsigned, saturate, 16-bit operands, 64-bit accumulator in LO, and return of HI or LO. It also returns the two source register indices, so that the surrounding register file can read the operands.

The unit checks that both operands are in canonical form for the selected width and signedness. It then forms the product, adds it to or subtracts it from the left-hand value, and saturates the result if asked. It writes the result to HI/LO, split across the two registers or held whole in LO. A single registered result stage presents the write-back value, the destination index and the two error flags. Operations with a non-canonical operand and words that decode to no operation leave HI/LO untouched and raise a flag.

Top module: `mac_unit`

## Requirements
- R1: After reset, acc_hi and acc_lo read zero, out_valid is low and in_ready is high.
- R2: in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, the registered result and HI/LO hold, and no new operation is taken.
- R3: Accumulating form: instr[31:26]=000000, instr[8:7]=00 and instr[5:1]=10100. instr[0]=1 selects the 64-bit accumulator in LO. instr[10] selects saturation and also 16-bit operands. instr[9] selects HI for return. instr[6] selects unsigned. The operation always accumulates and never subtracts.
- R4: Plain form: instr[31:26]=000000, instr[10]=0, instr[5:1]=01100 and instr[6]=1. instr[8] means accumulate, instr[7] means subtract, instr[9] selects HI and instr[0] selects unsigned. Operands are 32-bit, there is no saturation and the accumulator is split. So instr[8:6] of 001 multiplies, 011 negates the product, 101 adds the product and 111 subtracts it.
- R5: Any other word sets err_illegal, clears wr_en and leaves HI/LO unchanged.
- R6: An operand is canonical in one of three ways. In 32-bit mode it equals the sign extension of its low 32 bits. In 16-bit unsigned mode it equals its low 16 bits zero-extended. In 16-bit signed mode it equals its low 16 bits sign-extended. If either operand is not canonical, err_operand is set, wr_en is cleared and HI/LO are unchanged.
- R7: The left-hand value is zero when not accumulating. With the 64-bit accumulator it is LO. Otherwise it is HI[31:0] placed above LO[31:0].
- R8: The product multiplies the low 32 bits of both operands, zero-extended when unsigned and sign-extended when signed. The result is the left-hand value plus or minus the product, modulo 2^64.
- R9: Signed saturation acts when the 64-bit result differs from the sign extension of its low 32 bits. A non-negative result clamps to 0x000000007FFFFFFF and a negative one to 0xFFFFFFFF80000000.
- R10: Unsigned saturation forces all 64 bits to one when any of result bits 63:32 is set, and leaves an in-range result unchanged.
- R11: With the 64-bit accumulator, LO takes the whole result and HI is unchanged. Otherwise LO takes the sign-extended result[31:0] and HI the sign-extended result[63:32].
- R12: instr[15:11] is the destination. When it is nonzero, wr_en is set and wr_data is the new HI if instr[9] is set, or the new LO if it is clear. A destination of zero gives wr_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| instr | input | 32 | Instruction word |
| op_a | input | 64 | First source register value |
| op_b | input | 64 | Second source register value |
| src_a_idx | output | 5 | First source register index, from instr[25:21] |
| src_b_idx | output | 5 | Second source register index, from instr[20:16] |
| out_valid | output | 1 | Result stage holds a finished operation |
| out_ready | input | 1 | Consumer takes the result |
| wr_en | output | 1 | Register write requested |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | 64 | HI or LO value to write |
| err_operand | output | 1 | Operand not in canonical form |
| err_illegal | output | 1 | Instruction word not recognised |
| acc_hi | output | 64 | Current HI register |
| acc_lo | output | 64 | Current LO register |

## Verification
The bench chains operations so that each one's left-hand value comes from the HI/LO state left by the one before. A unit that built the split accumulator from the wrong halves, or that accumulated when it should start from zero, therefore gives a wrong sum. Saturation is driven just past both signed limits, and both just past and inside the unsigned limit. This catches a clamp with the wrong sign or one that also fires on in-range results. The canonical-form test uses operands that pass in one mode and fail in another, such as 0x8000 as a signed 16-bit value and 0x1_0000_0000 as a 32-bit value. A broken checker would then either update HI/LO or refuse a valid operation. A stalled consumer tests that a result held in the stage is not overwritten, and two unused operation codes test that illegal words leave the accumulator alone.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int MAC_W     = 64;
  localparam int MAC_HALF  = MAC_W / 2;
  localparam int MAC_SHORT = 16;
  localparam int REG_IDX_W = 5;

  typedef struct packed {
    logic                 legal;
    logic                 acc;
    logic                 sub;
    logic                 uns;
    logic                 sat;
    logic                 shrt;
    logic                 dbl;
    logic                 hisel;
    logic [REG_IDX_W-1:0] dest;
  } mac_ctrl_t;
endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_pkg::*;
(
  input  logic [31:0]          instr,
  output mac_ctrl_t            ctrl,
  output logic [REG_IDX_W-1:0] src_a,
  output logic [REG_IDX_W-1:0] src_b
);
  logic prim_ok;
  logic form_acc;
  logic form_plain;

  assign prim_ok    = (instr[31:26] == 6'b000000);
  assign form_acc   = prim_ok && (instr[8:7] == 2'b00) && (instr[5:1] == 5'b10100);
  assign form_plain = prim_ok && !instr[10] && instr[6] && (instr[5:1] == 5'b01100);

  assign src_a = instr[25:21];
  assign src_b = instr[20:16];

  always_comb begin
    ctrl       = '0;
    ctrl.dest  = instr[15:11];
    ctrl.hisel = instr[9];
    if (form_acc) begin
      ctrl.legal = 1'b1;
      ctrl.acc   = 1'b1;
      ctrl.sub   = 1'b0;
      ctrl.uns   = instr[6];
      ctrl.sat   = instr[10];
      ctrl.shrt  = instr[10];
      ctrl.dbl   = instr[0];
    end else if (form_plain) begin
      ctrl.legal = 1'b1;
      ctrl.acc   = instr[8];
      ctrl.sub   = instr[7];
      ctrl.uns   = instr[0];
      ctrl.sat   = 1'b0;
      ctrl.shrt  = 1'b0;
      ctrl.dbl   = 1'b0;
    end
  end
endmodule

// File: rtl/mac_opcheck.sv
module mac_opcheck #(
  parameter int W     = mac_pkg::MAC_W,
  parameter int HALF  = mac_pkg::MAC_HALF,
  parameter int SHORT = mac_pkg::MAC_SHORT
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         shrt,
  input  logic         uns,
  output logic         bad
);
  localparam int NOPS = 2;

  logic [W-1:0]    ops  [NOPS];
  logic [NOPS-1:0] fail;

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    logic [W-1:0] canon;
    always_comb begin
      if (!shrt)
        canon = {{(W-HALF){ops[g][HALF-1]}}, ops[g][HALF-1:0]};
      else if (uns)
        canon = {{(W-SHORT){1'b0}}, ops[g][SHORT-1:0]};
      else
        canon = {{(W-SHORT){ops[g][SHORT-1]}}, ops[g][SHORT-1:0]};
    end
    assign fail[g] = (canon != ops[g]);
  end

  assign bad = |fail;
endmodule

// File: rtl/mac_arith.sv
module mac_arith #(
  parameter int W    = mac_pkg::MAC_W,
  parameter int HALF = mac_pkg::MAC_HALF
) (
  input  logic            acc,
  input  logic            sub,
  input  logic            uns,
  input  logic            sat,
  input  logic            dbl,
  input  logic            hisel,
  input  logic [HALF-1:0] a_lo,
  input  logic [HALF-1:0] b_lo,
  input  logic [W-1:0]    hi,
  input  logic [W-1:0]    lo,
  output logic [W-1:0]    hi_n,
  output logic [W-1:0]    lo_n,
  output logic [W-1:0]    ret_val
);
  localparam logic [W-1:0] SMAX = {{(W-HALF+1){1'b0}}, {(HALF-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {{(W-HALF+1){1'b1}}, {(HALF-1){1'b0}}};

  logic [W-1:0] lhs;
  logic [W-1:0] ea;
  logic [W-1:0] eb;
  logic [W-1:0] prod;
  logic [W-1:0] raw;
  logic [W-1:0] res;
  logic         s_ovf;
  logic         u_ovf;

  always_comb begin
    if (!acc)     lhs = '0;
    else if (dbl) lhs = lo;
    else          lhs = {hi[HALF-1:0], lo[HALF-1:0]};
  end

  assign ea   = uns ? {{(W-HALF){1'b0}}, a_lo} : {{(W-HALF){a_lo[HALF-1]}}, a_lo};
  assign eb   = uns ? {{(W-HALF){1'b0}}, b_lo} : {{(W-HALF){b_lo[HALF-1]}}, b_lo};
  assign prod = ea * eb;
  assign raw  = sub ? (lhs - prod) : (lhs + prod);

  assign s_ovf = (raw != {{(W-HALF){raw[HALF-1]}}, raw[HALF-1:0]});
  assign u_ovf = |raw[W-1:HALF];

  always_comb begin
    res = raw;
    if (sat) begin
      if (!uns && s_ovf)     res = raw[W-1] ? SMIN : SMAX;
      else if (uns && u_ovf) res = '1;
    end
  end

  always_comb begin
    if (dbl) begin
      lo_n = res;
      hi_n = hi;
    end else begin
      lo_n = {{(W-HALF){res[HALF-1]}}, res[HALF-1:0]};
      hi_n = {{(W-HALF){res[W-1]}}, res[W-1:HALF]};
    end
    ret_val = hisel ? hi_n : lo_n;
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [31:0]          instr,
  input  logic [MAC_W-1:0]     op_a,
  input  logic [MAC_W-1:0]     op_b,
  output logic [REG_IDX_W-1:0] src_a_idx,
  output logic [REG_IDX_W-1:0] src_b_idx,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 wr_en,
  output logic [REG_IDX_W-1:0] wr_idx,
  output logic [MAC_W-1:0]     wr_data,
  output logic                 err_operand,
  output logic                 err_illegal,
  output logic [MAC_W-1:0]     acc_hi,
  output logic [MAC_W-1:0]     acc_lo
);
  logic [1:0]           rst_sync;
  logic                 rst_n_s;
  mac_ctrl_t            ctrl;
  logic                 bad;
  logic [MAC_W-1:0]     hi_n, lo_n, ret_val;
  logic                 accept, commit;

  logic [MAC_W-1:0]     hi_q, hi_d, lo_q, lo_d;
  logic                 vld_q, vld_d;
  logic                 wen_q, wen_d;
  logic [REG_IDX_W-1:0] idx_q, idx_d;
  logic [MAC_W-1:0]     dat_q, dat_d;
  logic                 eop_q, eop_d, eil_q, eil_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  mac_decode u_dec (
    .instr (instr),
    .ctrl  (ctrl),
    .src_a (src_a_idx),
    .src_b (src_b_idx)
  );

  mac_opcheck #(.W(MAC_W), .HALF(MAC_HALF), .SHORT(MAC_SHORT)) u_chk (
    .op_a (op_a),
    .op_b (op_b),
    .shrt (ctrl.shrt),
    .uns  (ctrl.uns),
    .bad  (bad)
  );

  mac_arith #(.W(MAC_W), .HALF(MAC_HALF)) u_alu (
    .acc     (ctrl.acc),
    .sub     (ctrl.sub),
    .uns     (ctrl.uns),
    .sat     (ctrl.sat),
    .dbl     (ctrl.dbl),
    .hisel   (ctrl.hisel),
    .a_lo    (op_a[MAC_HALF-1:0]),
    .b_lo    (op_b[MAC_HALF-1:0]),
    .hi      (hi_q),
    .lo      (lo_q),
    .hi_n    (hi_n),
    .lo_n    (lo_n),
    .ret_val (ret_val)
  );

  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;
  assign commit   = accept && ctrl.legal && !bad;

  always_comb begin
    hi_d  = hi_q;
    lo_d  = lo_q;
    vld_d = vld_q;
    wen_d = wen_q;
    idx_d = idx_q;
    dat_d = dat_q;
    eop_d = eop_q;
    eil_d = eil_q;
    if (commit) begin
      hi_d = hi_n;
      lo_d = lo_n;
    end
    if (accept) begin
      vld_d = 1'b1;
      wen_d = commit && (ctrl.dest != '0);
      idx_d = ctrl.dest;
      dat_d = ret_val;
      eop_d = ctrl.legal && bad;
      eil_d = !ctrl.legal;
    end else if (out_ready) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      hi_q  <= '0;
      lo_q  <= '0;
      vld_q <= 1'b0;
      wen_q <= 1'b0;
      idx_q <= '0;
      dat_q <= '0;
      eop_q <= 1'b0;
      eil_q <= 1'b0;
    end else begin
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      vld_q <= vld_d;
      wen_q <= wen_d;
      idx_q <= idx_d;
      dat_q <= dat_d;
      eop_q <= eop_d;
      eil_q <= eil_d;
    end
  end

  assign out_valid   = vld_q;
  assign wr_en       = wen_q;
  assign wr_idx      = idx_q;
  assign wr_data     = dat_q;
  assign err_operand = eop_q;
  assign err_illegal = eil_q;
  assign acc_hi      = hi_q;
  assign acc_lo      = lo_q;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (vld_q && !out_ready) |=> (vld_q && $stable(dat_q) && $stable(hi_q) && $stable(lo_q)));

  assert_illegal_keep_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (accept && !ctrl.legal) |=> ($stable(hi_q) && $stable(lo_q) && eil_q && !wen_q));

  assert_bad_keep_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (accept && ctrl.legal && bad) |=> ($stable(hi_q) && $stable(lo_q) && eop_q && !wen_q));

  assert_ssat_range_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (commit && ctrl.sat && !ctrl.uns) |=> (lo_q == {{(MAC_W-MAC_HALF){lo_q[MAC_HALF-1]}}, lo_q[MAC_HALF-1:0]}));

  assert_usat_range_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (commit && ctrl.sat && ctrl.uns && ctrl.dbl) |=> ((lo_q[MAC_W-1:MAC_HALF] == '0) || (lo_q == '1)));

  assert_dbl_hi_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (commit && ctrl.dbl) |=> $stable(hi_q));

  assert_wr_idx_R12: assert property (@(posedge clk) disable iff (!rst_n_s)
    wen_q |-> (idx_q != '0));
endmodule

// File: tb/mac_unit_tb.sv
module mac_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [31:0] instr;
  logic [63:0] op_a, op_b;
  logic [4:0]  src_a_idx, src_b_idx, wr_idx;
  logic        wr_en, err_operand, err_illegal;
  logic [63:0] wr_data, acc_hi, acc_lo;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  always #4 clk = ~clk;

  mac_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .instr(instr), .op_a(op_a), .op_b(op_b),
    .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .out_valid(out_valid), .out_ready(out_ready),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .err_operand(err_operand), .err_illegal(err_illegal),
    .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  function automatic logic [31:0] f_acc(input logic [4:0] rd, input logic sat,
                                        input logic hs, input logic un, input logic dbl);
    return {6'b000000, 5'd1, 5'd2, rd, sat, hs, 2'b00, un, 5'b10100, dbl};
  endfunction

  function automatic logic [31:0] f_plain(input logic [4:0] rd, input logic hs,
                                          input logic [2:0] op, input logic un);
    return {6'b000000, 5'd1, 5'd2, rd, 1'b0, hs, op, 5'b01100, un};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    instr = w; op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 hi", acc_hi, 0);
    chk("R1 lo", acc_lo, 0);
    chk("R1 out_valid", {63'd0, out_valid}, 0);
    chk("R1 in_ready", {63'd0, in_ready}, 1);
  endtask

  task automatic t_plain;
    issue(f_plain(5'd5, 1'b0, 3'b001, 1'b0), 64'hFFFF_FFFF_FFFF_FFFD, 64'd7);
    chk("R4 mul lo", acc_lo, 64'hFFFF_FFFF_FFFF_FFEB);
    chk("R11 mul hi", acc_hi, ONES);
    chk("R12 wr_en", {63'd0, wr_en}, 1);
    chk("R12 wr_idx", {59'd0, wr_idx}, 5);
    chk("R12 wr_data lo", wr_data, 64'hFFFF_FFFF_FFFF_FFEB);
    issue(f_plain(5'd6, 1'b1, 3'b001, 1'b1), ONES, 64'd2);
    chk("R8 unsigned lo", acc_lo, 64'hFFFF_FFFF_FFFF_FFFE);
    chk("R8 unsigned hi", acc_hi, 64'd1);
    chk("R12 wr_data hi", wr_data, 64'd1);
    issue(f_plain(5'd6, 1'b0, 3'b101, 1'b0), 64'd1, 64'd2);
    chk("R7 split lhs lo", acc_lo, 64'd0);
    chk("R7 split lhs hi", acc_hi, 64'd2);
    issue(f_plain(5'd6, 1'b0, 3'b111, 1'b0), 64'd1, 64'd1);
    chk("R4 msub lo", acc_lo, ONES);
    chk("R4 msub hi", acc_hi, 64'd1);
    issue(f_plain(5'd6, 1'b0, 3'b011, 1'b0), 64'd5, 64'd6);
    chk("R7 no-acc neg lo", acc_lo, 64'hFFFF_FFFF_FFFF_FFE2);
    chk("R7 no-acc neg hi", acc_hi, ONES);
  endtask

  task automatic t_acc_form;
    issue(f_acc(5'd0, 1'b0, 1'b0, 1'b0, 1'b0), 64'd10, 64'd3);
    chk("R3 single lo", acc_lo, 64'd0);
    chk("R3 single hi", acc_hi, 64'd0);
    chk("R12 rd0 no write", {63'd0, wr_en}, 0);
    issue(f_acc(5'd3, 1'b0, 1'b1, 1'b0, 1'b1), 64'h7FFF_FFFF, 64'h7FFF_FFFF);
    chk("R11 dbl lo", acc_lo, 64'h3FFF_FFFF_0000_0001);
    chk("R11 dbl hi kept", acc_hi, 64'd0);
    chk("R12 dbl ret hi", wr_data, 64'd0);
    issue(f_acc(5'd3, 1'b0, 1'b0, 1'b0, 1'b1), 64'h7FFF_FFFF, 64'h7FFF_FFFF);
    chk("R7 dbl lhs", acc_lo, 64'h7FFF_FFFE_0000_0002);
    chk("R12 dbl ret lo", wr_data, 64'h7FFF_FFFE_0000_0002);
  endtask

  task automatic t_ssat;
    issue(f_plain(5'd4, 1'b0, 3'b001, 1'b0), 64'h7FFF_FFFF, 64'd1);
    issue(f_acc(5'd4, 1'b1, 1'b0, 1'b0, 1'b0), 64'h7FFF, 64'h7FFF);
    chk("R9 clamp pos lo", acc_lo, 64'h0000_0000_7FFF_FFFF);
    chk("R9 clamp pos hi", acc_hi, 64'd0);
    issue(f_plain(5'd4, 1'b0, 3'b001, 1'b0), 64'hFFFF_FFFF_8000_0000, 64'd1);
    issue(f_acc(5'd4, 1'b1, 1'b0, 1'b0, 1'b0), ONES, 64'd1);
    chk("R9 clamp neg lo", acc_lo, 64'hFFFF_FFFF_8000_0000);
    chk("R9 clamp neg hi", acc_hi, ONES);
  endtask

  task automatic t_usat;
    issue(f_plain(5'd4, 1'b0, 3'b001, 1'b1), ONES, 64'd1);
    chk("R8 unsigned max lo", acc_lo, ONES);
    chk("R8 unsigned max hi", acc_hi, 64'd0);
    issue(f_acc(5'd4, 1'b1, 1'b0, 1'b1, 1'b0), 64'd1, 64'd1);
    chk("R10 overflow lo", acc_lo, ONES);
    chk("R10 overflow hi", acc_hi, ONES);
    issue(f_plain(5'd4, 1'b0, 3'b001, 1'b1), 64'd5, 64'd6);
    issue(f_acc(5'd4, 1'b1, 1'b0, 1'b1, 1'b0), 64'd2, 64'd3);
    chk("R10 in range lo", acc_lo, 64'd36);
    chk("R10 in range hi", acc_hi, 64'd0);
  endtask

  task automatic t_operand;
    issue(f_plain(5'd4, 1'b0, 3'b001, 1'b0), 64'h1_0000_0000, 64'd1);
    chk("R6 32b err", {63'd0, err_operand}, 1);
    chk("R6 32b no write", {63'd0, wr_en}, 0);
    chk("R6 32b lo kept", acc_lo, 64'd36);
    issue(f_acc(5'd4, 1'b1, 1'b0, 1'b1, 1'b0), 64'h1_0000, 64'd1);
    chk("R6 u16 err", {63'd0, err_operand}, 1);
    chk("R6 u16 lo kept", acc_lo, 64'd36);
    issue(f_acc(5'd4, 1'b1, 1'b0, 1'b0, 1'b0), 64'd1, 64'h8000);
    chk("R6 s16 err", {63'd0, err_operand}, 1);
    chk("R6 s16 lo kept", acc_lo, 64'd36);
    issue(f_acc(5'd4, 1'b1, 1'b0, 1'b1, 1'b0), 64'hFFFF, 64'd1);
    chk("R6 u16 ok flag", {63'd0, err_operand}, 0);
    chk("R6 u16 ok lo", acc_lo, 64'd65571);
  endtask

  task automatic t_illegal;
    issue(32'hFFFF_FFFF, 64'd3, 64'd3);
    chk("R5 all ones flag", {63'd0, err_illegal}, 1);
    chk("R5 all ones no write", {63'd0, wr_en}, 0);
    chk("R5 lo kept", acc_lo, 64'd65571);
    issue(f_plain(5'd4, 1'b0, 3'b000, 1'b0), 64'd3, 64'd3);
    chk("R5 op000 flag", {63'd0, err_illegal}, 1);
    chk("R5 op000 lo kept", acc_lo, 64'd65571);
    chk("R5 hi kept", acc_hi, 64'd0);
  endtask

  task automatic t_stall;
    @(negedge clk);
    out_ready = 1'b0;
    instr = f_plain(5'd7, 1'b0, 3'b001, 1'b0); op_a = 64'd2; op_b = 64'd3; in_valid = 1'b1;
    @(negedge clk);
    chk("R2 first taken", wr_data, 64'd6);
    chk("R2 ready low", {63'd0, in_ready}, 0);
    instr = f_plain(5'd7, 1'b0, 3'b001, 1'b0); op_a = 64'd7; op_b = 64'd7;
    @(negedge clk);
    chk("R2 held data", wr_data, 64'd6);
    chk("R2 held lo", acc_lo, 64'd6);
    chk("R2 held valid", {63'd0, out_valid}, 1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 second taken", wr_data, 64'd49);
    chk("R2 second lo", acc_lo, 64'd49);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    instr = '0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_plain;
    t_acc_form;
    t_ssat;
    t_usat;
    t_operand;
    t_illegal;
    @(negedge clk);
    t_stall;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule